// File: doc/BRIEF.md
# Security Attribution and Gateway Checker

This block sits between a processor core (and its debug port) and the system bus. It decides whether each address belongs to secure memory, non-secure memory, or secure memory that non-secure code may call into (the callable kind). The decision combines a small set of programmable internal regions with a classification supplied by a fixed system-level map outside the block. Every data access leaves with a non-secure bus bit taken from that decision. A non-secure requester that touches secure or callable memory gets a fault.

For instruction fetches the block also tracks the security state of the executing code. That state follows the address being fetched. Non-secure code may move into secure state only by fetching a gateway marker instruction that lies in callable memory. The memory decode that sees the fetched word flags the marker on an input. A separate return request kind moves secure code back to non-secure state, and only when the return target is non-secure memory. Each request produces one registered response in the next cycle.

Top module: `sec_attr_gate`

## Requirements
- R1: After reset the core is in secure state (`cur_secure`=1), `rsp_valid` is 0, and all internal regions are disabled, so every address attributes as secure (`rsp_attr`=0).
- R2: An enabled internal region matches when the 32-byte granule number `req_addr[31:5]` lies between its base and limit, both ends included. A match makes the address non-secure, or callable if the region's callable bit is set. An address that no enabled region matches is secure.
- R3: When several enabled regions match, the region with the lowest index decides the internal result.
- R4: The external map reads as non-secure when `ext_ns`=1, otherwise as callable when `ext_nsc`=1, otherwise as secure. The reported attribute is the more secure of the internal and external results, ranked secure above callable above non-secure. `rsp_attr` is encoded as 0 secure, 1 non-secure, 2 callable.
- R5: For loads (`req_kind`=0) and stores (`req_kind`=1), `rsp_ns`=1 exactly when the attribute is non-secure. A non-secure requester accessing secure or callable memory gets `rsp_fault`=1. A secure requester never faults on data.
- R6: A fetch (`req_kind`=2) in non-secure state that targets callable memory with `req_gate`=1 sets `rsp_sec_enter` and moves to secure state. A callable target without the marker faults and leaves the state unchanged.
- R7: The gateway marker has no effect outside callable memory. In non-secure state, a fetch of non-secure memory stays non-secure without a fault, and a fetch of secure memory faults.
- R8: A fetch in secure state of secure or callable memory succeeds. A fetch in secure state of non-secure memory faults and leaves the state secure.
- R9: A return request (`req_kind`=3) in secure state whose target is non-secure memory switches to non-secure state without a fault. Any other return request faults and leaves the state unchanged.
- R10: A debugger request (`req_dbg`=1) is always checked as a data access, using `req_dbg_ns` as the requester's security. It never changes the security state and never raises `rsp_sec_enter`.
- R11: The response to a request sampled at a clock edge appears after that edge, and `rsp_valid` is 0 after an edge with no request. A region write takes effect for requests sampled from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one internal region |
| cfg_idx | input | 3 | Index of the region written |
| cfg_base | input | 27 | First granule of the region |
| cfg_limit | input | 27 | Last granule of the region |
| cfg_en | input | 1 | Region enable |
| cfg_nsc | input | 1 | Region is callable from non-secure code |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 return to non-secure |
| req_addr | input | 32 | Request address |
| req_dbg | input | 1 | Request comes from the debugger |
| req_dbg_ns | input | 1 | Debugger request is non-secure |
| req_gate | input | 1 | Fetched word is the gateway marker |
| ext_ns | input | 1 | External map: address is non-secure |
| ext_nsc | input | 1 | External map: address is callable |
| rsp_valid | output | 1 | Response present |
| rsp_attr | output | 2 | Resolved attribute |
| rsp_ns | output | 1 | Non-secure bus attribute |
| rsp_fault | output | 1 | Security fault |
| rsp_sec_enter | output | 1 | Valid gateway entry into secure state |
| cur_secure | output | 1 | Current security state of the core |

## Verification
The assertions check on every cycle that the security state changes only together with a fault-free response, that a fault never moves the state, that gateway entry happens only into callable memory and ends in secure state, that falling out of secure state lands on non-secure memory, that debugger requests leave the state alone, and that a secure external classification always wins. The bench scenarios are needed for the rest: inclusive region bounds, lowest-index priority among overlapping regions, the marker being ignored outside callable memory, region writes taking effect one edge later, and the cleared configuration after a reset in mid-run.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [1:0] {
    ATTR_S   = 2'd0,
    ATTR_NS  = 2'd1,
    ATTR_NSC = 2'd2
  } attr_e;

  typedef enum logic [1:0] {
    K_LOAD   = 2'd0,
    K_STORE  = 2'd1,
    K_FETCH  = 2'd2,
    K_RETURN = 2'd3
  } kind_e;

  // Rank: secure above callable above non-secure
  function automatic attr_e more_secure(attr_e a, attr_e b);
    if (a == ATTR_S || b == ATTR_S) return ATTR_S;
    if (a == ATTR_NSC || b == ATTR_NSC) return ATTR_NSC;
    return ATTR_NS;
  endfunction

endpackage

// File: rtl/sag_region.sv
module sag_region #(
  parameter int PAGE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_base,
  input  logic [PAGE_W-1:0] wr_limit,
  input  logic              wr_valid,
  input  logic              wr_nsc,
  input  logic [PAGE_W-1:0] look_page,
  output logic              hit,
  output logic              is_nsc
);

  logic [PAGE_W-1:0] base_q, base_d;
  logic [PAGE_W-1:0] limit_q, limit_d;
  logic              en_q, en_d;
  logic              nsc_q, nsc_d;

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    en_d    = en_q;
    nsc_d   = nsc_q;
    if (wr_en) begin
      base_d  = wr_base;
      limit_d = wr_limit;
      en_d    = wr_valid;
      nsc_d   = wr_nsc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      en_q    <= 1'b0;
      nsc_q   <= 1'b0;
    end else if (wr_en) begin
      base_q  <= base_d;
      limit_q <= limit_d;
      en_q    <= en_d;
      nsc_q   <= nsc_d;
    end
  end

  assign hit    = en_q && (look_page >= base_q) && (look_page <= limit_q);
  assign is_nsc = nsc_q;

endmodule

// File: rtl/sag_attr_merge.sv
module sag_attr_merge
  import sag_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0] hit,
  input  logic [NREG-1:0] nsc,
  input  logic            ext_ns,
  input  logic            ext_nsc,
  output attr_e           attr
);

  attr_e int_attr;
  attr_e ext_attr;

  // Walk from the highest index down so the lowest index is applied last
  always_comb begin
    int_attr = ATTR_S;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) int_attr = nsc[i] ? ATTR_NSC : ATTR_NS;
    end
  end

  always_comb begin
    if (ext_ns)       ext_attr = ATTR_NS;
    else if (ext_nsc) ext_attr = ATTR_NSC;
    else              ext_attr = ATTR_S;
  end

  assign attr = more_secure(int_attr, ext_attr);

endmodule

// File: rtl/sag_state.sv
module sag_state
  import sag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] kind,
  input  logic       dbg,
  input  logic       dbg_ns,
  input  logic       gate,
  input  attr_e      attr,
  output logic       rsp_valid,
  output attr_e      rsp_attr,
  output logic       rsp_ns,
  output logic       rsp_fault,
  output logic       rsp_enter,
  output logic       cur_secure
);

  logic  sec_q, sec_d;
  logic  vld_q;
  attr_e attr_q;
  logic  fault_q, fault_d;
  logic  enter_q, enter_d;
  logic  req_is_ns;
  logic  tgt_ns;

  assign req_is_ns = dbg ? dbg_ns : !sec_q;
  assign tgt_ns    = (attr == ATTR_NS);

  always_comb begin
    sec_d   = sec_q;
    fault_d = 1'b0;
    enter_d = 1'b0;
    if (req_valid) begin
      if (dbg || kind == K_LOAD || kind == K_STORE) begin
        fault_d = req_is_ns && !tgt_ns;
      end else if (kind == K_FETCH) begin
        if (!sec_q) begin
          if (attr == ATTR_NSC && gate) begin
            enter_d = 1'b1;
            sec_d   = 1'b1;
          end else if (!tgt_ns) begin
            fault_d = 1'b1;
          end
        end else if (tgt_ns) begin
          fault_d = 1'b1;
        end
      end else begin
        if (sec_q && tgt_ns) sec_d = 1'b0;
        else                 fault_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= 1'b1;
      vld_q   <= 1'b0;
      attr_q  <= ATTR_S;
      fault_q <= 1'b0;
      enter_q <= 1'b0;
    end else begin
      sec_q   <= sec_d;
      vld_q   <= req_valid;
      fault_q <= fault_d;
      enter_q <= enter_d;
      if (req_valid) attr_q <= attr;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_attr   = attr_q;
  assign rsp_ns     = (attr_q == ATTR_NS);
  assign rsp_fault  = fault_q;
  assign rsp_enter  = enter_q;
  assign cur_secure = sec_q;

  AST_ENTER_INTO_CALLABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_enter |-> (rsp_attr == ATTR_NSC && !rsp_fault && cur_secure)); // R6

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> $stable(cur_secure)); // R8

  AST_STATE_MOVES_CLEANLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_secure) |-> (rsp_valid && !rsp_fault)); // R9

  AST_EXIT_LANDS_NS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur_secure) |-> (rsp_attr == ATTR_NS)); // R9

  AST_DEBUG_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dbg) |=> ($stable(cur_secure) && !rsp_enter)); // R10

endmodule

// File: rtl/sec_attr_gate.sv
module sec_attr_gate
  import sag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 5,
  parameter int NREG    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NREG)-1:0]   cfg_idx,
  input  logic [ADDR_W-GRAN_LG-1:0] cfg_base,
  input  logic [ADDR_W-GRAN_LG-1:0] cfg_limit,
  input  logic                      cfg_en,
  input  logic                      cfg_nsc,
  input  logic                      req_valid,
  input  logic [1:0]                req_kind,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_dbg,
  input  logic                      req_dbg_ns,
  input  logic                      req_gate,
  input  logic                      ext_ns,
  input  logic                      ext_nsc,
  output logic                      rsp_valid,
  output logic [1:0]                rsp_attr,
  output logic                      rsp_ns,
  output logic                      rsp_fault,
  output logic                      rsp_sec_enter,
  output logic                      cur_secure
);

  localparam int PAGE_W = ADDR_W - GRAN_LG;
  localparam int IDX_W  = $clog2(NREG);

  logic [PAGE_W-1:0] page;
  logic              unused_low;
  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   nsc;
  attr_e             attr;
  attr_e             st_attr;

  assign page       = req_addr[ADDR_W-1:GRAN_LG];
  assign unused_low = ^req_addr[GRAN_LG-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_region
    sag_region #(.PAGE_W(PAGE_W)) u_region (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_idx == IDX_W'(i))),
      .wr_base   (cfg_base),
      .wr_limit  (cfg_limit),
      .wr_valid  (cfg_en),
      .wr_nsc    (cfg_nsc),
      .look_page (page),
      .hit       (hit[i]),
      .is_nsc    (nsc[i])
    );
  end

  sag_attr_merge #(.NREG(NREG)) u_merge (
    .hit     (hit),
    .nsc     (nsc),
    .ext_ns  (ext_ns),
    .ext_nsc (ext_nsc),
    .attr    (attr)
  );

  sag_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .kind       (req_kind),
    .dbg        (req_dbg),
    .dbg_ns     (req_dbg_ns),
    .gate       (req_gate),
    .attr       (attr),
    .rsp_valid  (rsp_valid),
    .rsp_attr   (st_attr),
    .rsp_ns     (rsp_ns),
    .rsp_fault  (rsp_fault),
    .rsp_enter  (rsp_sec_enter),
    .cur_secure (cur_secure)
  );

  assign rsp_attr = st_attr;

  AST_EXT_SECURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_ns && !ext_nsc) |=> (rsp_attr == ATTR_S)); // R4

  AST_NS_BIT_ONLY_NS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_ns) |=> !rsp_ns); // R5

endmodule

// File: tb/tb_sec_attr_gate.sv
module tb_sec_attr_gate;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [26:0] cfg_base;
  logic [26:0] cfg_limit;
  logic        cfg_en;
  logic        cfg_nsc;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic        req_dbg;
  logic        req_dbg_ns;
  logic        req_gate;
  logic        ext_ns;
  logic        ext_nsc;
  logic        rsp_valid;
  logic [1:0]  rsp_attr;
  logic        rsp_ns;
  logic        rsp_fault;
  logic        rsp_sec_enter;
  logic        cur_secure;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  sec_attr_gate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_en(cfg_en), .cfg_nsc(cfg_nsc),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_dbg(req_dbg), .req_dbg_ns(req_dbg_ns), .req_gate(req_gate),
    .ext_ns(ext_ns), .ext_nsc(ext_nsc),
    .rsp_valid(rsp_valid), .rsp_attr(rsp_attr), .rsp_ns(rsp_ns),
    .rsp_fault(rsp_fault), .rsp_sec_enter(rsp_sec_enter), .cur_secure(cur_secure)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Attribute codes: 0 secure, 1 non-secure, 2 callable
  // Kinds: 0 load, 1 store, 2 fetch, 3 return
  typedef struct packed {
    logic        dbg;
    logic        dbg_ns;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic        e_ns;
    logic        e_nsc;
    logic        gate;
    logic [1:0]  x_attr;
    logic        x_fault;
    logic        x_enter;
    logic        x_sec;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 26;
  // Regions: r0 granules 0x100..0x1FF non-secure, r1 0x200..0x20F callable,
  // r2 0x300..0x30F non-secure, r5 0x300..0x31F callable, r7 disabled
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,32'h2000,1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,1'b1,8'd5},  // R5 secure reads NS
    '{1'b0,1'b0,2'd0,32'h8000,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,8'd2},  // R2 no region
    '{1'b0,1'b0,2'd3,32'h2000,1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,8'd9},  // R9 return
    '{1'b0,1'b0,2'd0,32'h2000,1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,8'd5},  // R5
    '{1'b0,1'b0,2'd0,32'h1FE0,1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,8'd2},  // R2 below base
    '{1'b0,1'b0,2'd1,32'h3FE0,1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,8'd2},  // R2 at limit
    '{1'b0,1'b0,2'd0,32'h4000,1'b1,1'b0,1'b0,2'd2,1'b1,1'b0,1'b0,8'd5},  // R5 NS to callable
    '{1'b0,1'b0,2'd0,32'h2000,1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,8'd4},  // R4 ext secure
    '{1'b0,1'b0,2'd0,32'h2000,1'b0,1'b1,1'b0,2'd2,1'b1,1'b0,1'b0,8'd4},  // R4 ext callable
    '{1'b0,1'b0,2'd0,32'h6100,1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,8'd3},  // R3 r2 wins
    '{1'b0,1'b0,2'd0,32'h6300,1'b1,1'b0,1'b0,2'd2,1'b1,1'b0,1'b0,8'd3},  // R3 only r5
    '{1'b0,1'b0,2'd2,32'h2000,1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,8'd7},  // R7 marker in NS
    '{1'b0,1'b0,2'd2,32'h4000,1'b1,1'b0,1'b0,2'd2,1'b1,1'b0,1'b0,8'd6},  // R6 no marker
    '{1'b0,1'b0,2'd2,32'h8000,1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,8'd7},  // R7 marker in S
    '{1'b0,1'b0,2'd3,32'h2000,1'b1,1'b0,1'b0,2'd1,1'b1,1'b0,1'b0,8'd9},  // R9 return from NS
    '{1'b1,1'b0,2'd0,32'h8000,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,8'd10}, // R10 secure dbg
    '{1'b1,1'b1,2'd2,32'h4000,1'b1,1'b0,1'b1,2'd2,1'b1,1'b0,1'b0,8'd10}, // R10 dbg fetch
    '{1'b0,1'b0,2'd2,32'h41E0,1'b1,1'b0,1'b1,2'd2,1'b0,1'b1,1'b1,8'd6},  // R6 gateway
    '{1'b0,1'b0,2'd2,32'h8000,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,8'd8},  // R8
    '{1'b0,1'b0,2'd2,32'h2000,1'b1,1'b0,1'b0,2'd1,1'b1,1'b0,1'b1,8'd8},  // R8 S to NS fetch
    '{1'b0,1'b0,2'd3,32'h8000,1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,8'd9},  // R9 to secure
    '{1'b1,1'b1,2'd0,32'h8000,1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,8'd10}, // R10 NS dbg
    '{1'b0,1'b0,2'd0,32'h4000,1'b1,1'b0,1'b0,2'd2,1'b0,1'b0,1'b1,8'd5},  // R5
    '{1'b0,1'b0,2'd3,32'h6100,1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,8'd9},  // R9
    '{1'b0,1'b0,2'd2,32'h6300,1'b1,1'b0,1'b1,2'd2,1'b0,1'b1,1'b1,8'd6},  // R6 via r5
    '{1'b0,1'b0,2'd2,32'h4000,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,8'd4}   // R4
  };

  function automatic logic [6:0] observed();
    return {rsp_valid, rsp_attr, rsp_ns, rsp_fault, rsp_sec_enter, cur_secure};
  endfunction

  function automatic logic [6:0] expect_of(logic v, logic [1:0] a, logic f, logic e, logic s);
    return {v, a, (v && a == 2'd1), f, e, s};
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,attr,ns,fault,enter,sec} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic dn, input logic [1:0] k, input logic [31:0] a,
                       input logic en, input logic ec, input logic g);
    req_valid  = 1'b1;
    req_dbg    = d;
    req_dbg_ns = dn;
    req_kind   = k;
    req_addr   = a;
    ext_ns     = en;
    ext_nsc    = ec;
    req_gate   = g;
  endtask

  task automatic cfg_write(input int idx, input logic [26:0] b, input logic [26:0] l,
                           input logic en, input logic nsc);
    cfg_we    = 1'b1;
    cfg_idx   = 3'(idx);
    cfg_base  = b;
    cfg_limit = l;
    cfg_en    = en;
    cfg_nsc   = nsc;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_limit = '0;
    cfg_en = 1'b0; cfg_nsc = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0;
    req_dbg = 1'b0; req_dbg_ns = 1'b0; req_gate = 1'b0; ext_ns = 1'b0; ext_nsc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", observed(), expect_of(1'b0, 2'd0, 1'b0, 1'b0, 1'b1));

    // R1: regions off after reset, NS external map still yields secure
    drive(1'b0, 1'b0, 2'd0, 32'h2000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 unconfigured lookup", observed(), expect_of(1'b1, 2'd0, 1'b0, 1'b0, 1'b1));
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 idle gives no response", observed(), expect_of(1'b0, 2'd0, 1'b0, 1'b0, 1'b1));

    cfg_write(0, 27'h100, 27'h1FF, 1'b1, 1'b0);
    cfg_write(1, 27'h200, 27'h20F, 1'b1, 1'b1);
    cfg_write(2, 27'h300, 27'h30F, 1'b1, 1'b0);
    cfg_write(5, 27'h300, 27'h31F, 1'b1, 1'b1);
    cfg_write(7, 27'h400, 27'h4FF, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].dbg, VECS[i].dbg_ns, VECS[i].kind, VECS[i].addr,
            VECS[i].e_ns, VECS[i].e_nsc, VECS[i].gate);
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VECS[i].rq, i), observed(),
          expect_of(1'b1, VECS[i].x_attr, VECS[i].x_fault, VECS[i].x_enter, VECS[i].x_sec));
    end
    req_valid = 1'b0;

    // R11: region write and lookup in the same cycle sees the old setting
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_base = 27'h500; cfg_limit = 27'h50F;
    cfg_en = 1'b1; cfg_nsc = 1'b0;
    drive(1'b0, 1'b0, 2'd0, 32'hA000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 write not yet visible", observed(), expect_of(1'b1, 2'd0, 1'b0, 1'b0, 1'b1));
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R11 write visible next edge", observed(), expect_of(1'b1, 2'd1, 1'b0, 1'b0, 1'b1));

    // R1: reset in mid-run restores secure state and clears regions
    drive(1'b0, 1'b0, 2'd3, 32'h2000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 return before reset", observed(), expect_of(1'b1, 2'd1, 1'b0, 1'b0, 1'b0));
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset state", observed(), expect_of(1'b0, 2'd0, 1'b0, 1'b0, 1'b1));
    drive(1'b0, 1'b0, 2'd0, 32'h2000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 regions cleared", observed(), expect_of(1'b1, 2'd0, 1'b0, 1'b0, 1'b1));
    req_valid = 1'b0;
    @(negedge clk);

    done = 1;
    finish_run();
  end

endmodule